// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the 8-bit execution stage of a small processor datapath, built around an accumulator. Every two-operand operation takes the accumulator as its first operand and, except for compare, writes the result back into it. The second operand comes in on a byte-wide port. The surrounding core selects that byte from an immediate, a general register or a memory location reached through a 16-bit pointer pair. Instruction fetch, decoding and the register file belong to the surrounding core. The core presents a 4-bit operation code together with a one-cycle execute strobe.

Five flags sit next to the accumulator: sign, zero, parity (even count of ones), carry (borrow after a subtraction) and half carry (the carry from bit 3 into bit 4, kept for decimal adjustment). The accumulator and the flags are always visible as one 16-bit status word. A dedicated operation loads that word as a group, so the core can save and restore the state through its stack.

Top module: `acc_alu`

## Requirements
- R1: While reset is held low, and in the cycle after it is released, the status word reads 16'h0002: accumulator 0, all flags 0, and the constant bit 1 set.
- R2: Operation codes 0 (add) and 1 (add with carry) write A + B (+ CY for code 1) into the accumulator on the clock edge that samples the strobe. CY becomes the carry out of bit 7 and AC the carry out of bit 3.
- R3: Codes 2 (subtract) and 3 (subtract with borrow) write A − B (− CY for code 3). CY becomes 1 exactly when a borrow occurs. AC becomes the carry out of bit 3 of the sum A + ~B + (1 − borrow-in), where borrow-in is 0 for code 2 and CY for code 3.
- R4: Codes 4 (AND), 5 (XOR) and 6 (OR) write the bitwise result and clear CY and AC.
- R5: Code 7 (compare) updates all five flags exactly as code 2 would, and leaves the accumulator unchanged.
- R6: After codes 0 to 7, S equals result bit 7, Z is 1 when the 8-bit result is zero, and P is 1 when the result holds an even number of ones.
- R7: Code 8 inverts CY and code 9 sets CY. Neither changes the accumulator or any other flag.
- R8: The status word holds the accumulator in bits 15:8. Bits 7 down to 0 hold S, Z, 0, AC, 0, P, 1, CY. Code 10 loads the accumulator from input bits 15:8 and each flag from its own bit position. Bits 5, 3 and 1 keep their constant values whatever is loaded.
- R9: A cycle without the strobe, or with the strobe and a code from 11 to 15, leaves the status word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| exec_stb | input | 1 | One-cycle execute strobe |
| op_code | input | 4 | Operation selector |
| operand | input | 8 | Second operand byte |
| word_in | input | 16 | Status word to load (code 10) |
| status_word | output | 16 | Accumulator and flags |

## Verification
The hardest case to reach is a subtract with borrow that starts with CY already set and whose low nibble crosses zero. At that point the borrow-in, the half-carry convention and the borrow out all matter in the same cycle. The stimulus gets there in two ways. It sets the carry with code 9 or loads a prepared status word with code 10, and then issues code 3 with operands chosen so that the low nibbles are equal or off by one. A long run of strobed and idle cycles with mixed codes then follows, checked against a behavioural model on every clock.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
    localparam int DW  = 8;
    localparam int NIB = DW / 4;
    localparam int OPW = 4;
    localparam int SWW = 2 * DW;

    typedef enum logic [OPW-1:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBB = 4'd3,
        OP_AND = 4'd4,
        OP_XOR = 4'd5,
        OP_OR  = 4'd6,
        OP_CMP = 4'd7,
        OP_CMC = 4'd8,
        OP_STC = 4'd9,
        OP_LDW = 4'd10
    } op_e;

    typedef struct packed {
        logic s;
        logic z;
        logic ac;
        logic p;
        logic cy;
    } flags_t;

    function automatic logic [SWW-1:0] pack_word(input logic [DW-1:0] acc, input flags_t f);
        return {acc, f.s, f.z, 1'b0, f.ac, 1'b0, f.p, 1'b1, f.cy};
    endfunction
endpackage

// File: rtl/acc_alu_nibble.sv
module acc_alu_nibble (
    input  logic [3:0] x,
    input  logic [3:0] y,
    input  logic       ci,
    output logic [3:0] s,
    output logic       co
);
    logic [4:0] t;
    assign t  = {1'b0, x} + {1'b0, y} + {4'd0, ci};
    assign s  = t[3:0];
    assign co = t[4];
endmodule

// File: rtl/acc_alu_flags.sv
module acc_alu_flags
    import acc_alu_pkg::*;
(
    input  logic [DW-1:0] r,
    output logic          s,
    output logic          z,
    output logic          p
);
    assign s = r[DW-1];
    assign z = ~|r;
    assign p = ~^r;
endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
    import acc_alu_pkg::*;
(
    input  op_e           op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    output logic [DW-1:0] res,
    output logic          cy,
    output logic          ac
);
    logic          is_sub;
    logic [DW-1:0] b_eff;
    logic [DW-1:0] sum;
    logic [NIB:0]  ch;

    always_comb begin
        is_sub = (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP);
        b_eff  = is_sub ? ~b : b;
        case (op)
            OP_ADC:         ch[0] = cin;
            OP_SUB, OP_CMP: ch[0] = 1'b1;
            OP_SBB:         ch[0] = ~cin;
            default:        ch[0] = 1'b0;
        endcase
    end

    for (genvar i = 0; i < NIB; i++) begin : g_nib
        acc_alu_nibble u_nib (
            .x  (a[4*i +: 4]),
            .y  (b_eff[4*i +: 4]),
            .ci (ch[i]),
            .s  (sum[4*i +: 4]),
            .co (ch[i+1])
        );
    end

    always_comb begin
        case (op)
            OP_AND:  res = a & b;
            OP_XOR:  res = a ^ b;
            OP_OR:   res = a | b;
            default: res = sum;
        endcase
        cy = is_sub ? ~ch[NIB] : ch[NIB];
        ac = ch[1];
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           exec_stb,
    input  logic [3:0]     op_code,
    input  logic [7:0]     operand,
    input  logic [15:0]    word_in,
    output logic [15:0]    status_word
);
    op_e           opd;
    logic [DW-1:0] acc_q, acc_d;
    flags_t        fl_q, fl_d;
    logic [DW-1:0] res;
    logic          core_cy, core_ac;
    logic          r_s, r_z, r_p;

    assign opd = op_e'(op_code);

    acc_alu_core u_core (
        .op  (opd),
        .a   (acc_q),
        .b   (operand),
        .cin (fl_q.cy),
        .res (res),
        .cy  (core_cy),
        .ac  (core_ac)
    );

    acc_alu_flags u_flags (
        .r (res),
        .s (r_s),
        .z (r_z),
        .p (r_p)
    );

    always_comb begin
        acc_d = acc_q;
        fl_d  = fl_q;
        if (exec_stb) begin
            case (opd)
                OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
                    acc_d = res;
                    fl_d  = '{s: r_s, z: r_z, ac: core_ac, p: r_p, cy: core_cy};
                end
                OP_CMP: begin
                    fl_d  = '{s: r_s, z: r_z, ac: core_ac, p: r_p, cy: core_cy};
                end
                OP_AND, OP_XOR, OP_OR: begin
                    acc_d = res;
                    fl_d  = '{s: r_s, z: r_z, ac: 1'b0, p: r_p, cy: 1'b0};
                end
                OP_CMC: fl_d.cy = ~fl_q.cy;
                OP_STC: fl_d.cy = 1'b1;
                OP_LDW: begin
                    acc_d = word_in[15:8];
                    fl_d  = '{s: word_in[7], z: word_in[6], ac: word_in[4],
                              p: word_in[2], cy: word_in[0]};
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            fl_q  <= '0;
        end else begin
            acc_q <= acc_d;
            fl_q  <= fl_d;
        end
    end

    assign status_word = pack_word(acc_q, fl_q);
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
    import acc_alu_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        exec_stb,
    input logic [3:0]  op_code,
    input logic [15:0] status_word
);
    p_fixed_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word[5] == 1'b0) && (status_word[3] == 1'b0) && (status_word[1] == 1'b1));

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_stb |=> $stable(status_word));

    p_cmp_keeps_acc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_stb && op_code == 4'd7) |=> $stable(status_word[15:8]));

    p_logic_clears_cy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_stb && op_code >= 4'd4 && op_code <= 4'd6) |=> (status_word[0] == 1'b0 && status_word[4] == 1'b0));

    p_stc_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_stb && op_code == 4'd9) |=> (status_word[0] && $stable(status_word[15:1])));

    p_cmc_flips_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_stb && op_code == 4'd8) |=> (status_word[0] != $past(status_word[0])));

    p_parity_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_stb && op_code <= 4'd6) |=> (status_word[2] == ~^status_word[15:8]));

    p_zero_sign_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_stb && op_code <= 4'd6) |=>
            ((status_word[6] == (status_word[15:8] == 8'd0)) && (status_word[7] == status_word[15])));

    p_unused_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_stb && op_code >= 4'd11) |=> $stable(status_word));
endmodule

bind acc_alu acc_alu_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .exec_stb    (exec_stb),
    .op_code     (op_code),
    .status_word (status_word)
);

// File: tb/acc_alu_tb_top.sv
`timescale 1ns/1ps
module acc_alu_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exec_stb = 1'b0;
    logic [3:0]  op_code = 4'd0;
    logic [7:0]  operand = 8'd0;
    logic [15:0] word_in = 16'd0;
    logic [15:0] status_word;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    int m_acc = 0;
    bit m_s, m_z, m_ac, m_p, m_cy;

    always #4 clk = ~clk;

    acc_alu dut_i (
        .clk(clk), .rst_n(rst_n), .exec_stb(exec_stb), .op_code(op_code),
        .operand(operand), .word_in(word_in), .status_word(status_word)
    );

    function automatic logic [15:0] exp_word();
        return {m_acc[7:0], m_s, m_z, 1'b0, m_ac, 1'b0, m_p, 1'b1, m_cy};
    endfunction

    function automatic bit even_ones(input int v);
        int c = 0;
        for (int i = 0; i < 8; i++) c += (v >> i) & 1;
        return (c % 2) == 0;
    endfunction

    function automatic string tag_of(input bit s, input int op);
        if (!s || op > 10) return "R9";
        if (op <= 1) return "R2";
        if (op <= 3) return "R3";
        if (op <= 6) return "R4";
        if (op == 7) return "R5";
        if (op <= 9) return "R7";
        return "R8";
    endfunction

    task automatic check(input string req);
        n_checks++;
        if (status_word !== exp_word()) begin
            n_fail++;
            $display("FAIL %s: status_word actual %h expected %h", req, status_word, exp_word());
        end
    endtask

    task automatic model(input bit s, input int op, input int b, input logic [15:0] w);
        int r, t, bi;
        if (!s) return;
        case (op)
            0, 1: begin
                bi = (op == 1) ? m_cy : 0;
                t = m_acc + b + bi;
                m_ac = ((m_acc & 15) + (b & 15) + bi) > 15;
                m_cy = t > 255;
                r = t & 255;
            end
            2, 3, 7: begin
                bi = (op == 3) ? m_cy : 0;
                t = m_acc - b - bi;
                m_ac = ((m_acc & 15) + ((~b) & 15) + (1 - bi)) > 15;
                m_cy = t < 0;
                r = t & 255;
            end
            4: begin r = m_acc & b; m_cy = 0; m_ac = 0; end
            5: begin r = m_acc ^ b; m_cy = 0; m_ac = 0; end
            6: begin r = m_acc | b; m_cy = 0; m_ac = 0; end
            8: begin m_cy = !m_cy; return; end
            9: begin m_cy = 1; return; end
            10: begin
                m_acc = w[15:8]; m_s = w[7]; m_z = w[6]; m_ac = w[4]; m_p = w[2]; m_cy = w[0];
                return;
            end
            default: return;
        endcase
        m_s = r[7]; m_z = (r == 0); m_p = even_ones(r);
        if (op != 7) m_acc = r;
    endtask

    task automatic step(input bit s, input int op, input int b, input logic [15:0] w, input string req);
        exec_stb = s; op_code = op[3:0]; operand = b[7:0]; word_in = w;
        model(s, op, b, w);
        @(posedge clk);
        @(negedge clk);
        exec_stb = 1'b0;
        check(req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        m_acc = 0; {m_s, m_z, m_ac, m_p, m_cy} = '0;
        repeat (3) @(negedge clk);
        check("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1");

        step(1, 10, 0, 16'h0F00, "R8");
        step(1, 0, 8'h01, 0, "R2");        // half carry from low nibble
        step(1, 0, 8'hF0, 0, "R2");        // 0x10+0xF0 wraps to zero, carry out
        step(1, 1, 8'h7F, 0, "R2");        // add with carry in
        step(1, 10, 0, 16'h00FF, "R8");    // constant bits forced
        step(1, 2, 8'h01, 0, "R3");        // 0 - 1 borrows
        step(1, 9, 0, 0, "R7");
        step(1, 3, 8'h0F, 0, "R3");        // borrow-in with nibble crossing
        step(1, 10, 0, 16'h3001, "R8");
        step(1, 3, 8'h2F, 0, "R3");        // 0x30 - 0x2F - 1 = 0
        step(1, 7, 8'h55, 0, "R5");
        step(1, 7, 8'h00, 0, "R5");
        step(1, 9, 0, 0, "R7");
        step(1, 4, 8'h0F, 0, "R4");
        step(1, 9, 0, 0, "R7");
        step(1, 5, 8'hFF, 0, "R4");
        step(1, 6, 8'h81, 0, "R6");        // parity / sign pattern
        step(1, 8, 0, 0, "R7");
        step(1, 8, 0, 0, "R7");
        step(0, 0, 8'h33, 16'hFFFF, "R9");
        step(0, 10, 8'h33, 16'h1234, "R9");
        step(1, 11, 8'h33, 16'hFFFF, "R9");
        step(1, 15, 8'h33, 16'hFFFF, "R9");

        for (int k = 0; k < 600; k++) begin
            bit s = ($urandom % 5) != 0;
            int op = $urandom % 16;
            int b = $urandom % 256;
            logic [15:0] w = 16'($urandom);
            step(s, op, b, w, tag_of(s, op));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule